// File: doc/BRIEF.md
# Wavefront Crossbar Arbiter

This block schedules an N×N input-queued crossbar. Every cycle it takes a request matrix, where a set bit for the pair (input i, output j) says input i holds a cell bound for output j, and it returns a grant matrix that pairs inputs with outputs. No input gets two outputs and no output gets two inputs. The match is also maximal: no request is left standing between an input and an output that both stay unpaired.

The matrix is resolved in one feed-forward pass. It is split into N diagonals, and the cells on one diagonal never share a row or a column, so each diagonal settles all of its cells at once. Each diagonal then passes "row still open" and "column still open" vectors to the next one. The diagonal that is looked at first moves forward by one position on every clock edge. Over N cycles, every input/output pair therefore spends one cycle on the highest-priority diagonal. The grant matrix is registered, so a request pattern sampled on one edge shows up as grants just after that edge.

Top module: `wfa_arbiter`

## Requirements
- R1: `grant` is a register. The request pattern sampled on a rising edge of `clk` appears on `grant` after that edge. While `rst_n` is low, `grant` is all zero and the leading diagonal is 0.
- R2: A grant bit is set only where the matching request bit was set on the sampling edge.
- R3: Each input (row) receives at most one grant.
- R4: Each output (column) receives at most one grant.
- R5: The match is maximal. For every sampled request (i,j), input i or output j holds some grant.
- R6: Priority follows the diagonals. With leading diagonal s, wavefront k holds the cells where (i+j) mod N equals (s+k) mod N. A cell is granted when its request is set and no cell on an earlier wavefront has taken its row or its column.
- R7: The leading diagonal is 0 on the first edge after reset. It then goes up by one, modulo N, on every edge, whatever the requests are.
- R8: Bit i*N+j of `req` and `grant` stands for input i and output j. With N=4, nibble i holds row i, and bit j of that nibble is column j.
- R9: A request pattern that is a full permutation is granted in full.
- R10: An all-zero request pattern produces an all-zero grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N*N | Request matrix, bit i*N+j means input i wants output j |
| grant | output | N*N | Registered grant matrix, same bit layout as `req` |

## Verification
The block has two pieces of state: the grant register and the leading-diagonal counter. A fault in either one shows at `grant` one edge after the request pattern is sampled.

A broken open-row or open-column chain shows on that same edge as a double grant, a grant with no request behind it, or a request left idle. A counter that is stuck, skips, or restarts at the wrong value shows as the wrong winner on a contended column within N cycles. The bench makes that visible by checking hand-computed grant patterns against known diagonal positions right after reset.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    // Column of the cell in row `row` that lies on wavefront `wave`
    // when diagonal `lead` is served first.
    function automatic int unsigned diag_col(
        input int unsigned lead,
        input int unsigned wave,
        input int unsigned row,
        input int unsigned n
    );
        return (lead + wave + n - row) % n;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wfa_rotor.sv
module wfa_rotor #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] lead
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead <= '0;
        end else if (lead == LAST) begin
            lead <= '0;
        end else begin
            lead <= lead + 1'b1;
        end
    end

endmodule

// File: rtl/wfa_wave.sv
module wfa_wave #(
    parameter int N  = 4,
    parameter int K  = 0,
    parameter int IW = 2
) (
    input  logic [IW-1:0]  lead,
    input  logic [N*N-1:0] req,
    input  logic [N-1:0]   row_open_i,
    input  logic [N-1:0]   col_open_i,
    output logic [N*N-1:0] grant_o,
    output logic [N-1:0]   row_open_o,
    output logic [N-1:0]   col_open_o
);

    always_comb begin
        grant_o    = '0;
        row_open_o = row_open_i;
        col_open_o = col_open_i;
        for (int i = 0; i < N; i++) begin
            int unsigned c;
            c = wfa_pkg::diag_col(int'(lead), K, i, N);
            if (req[i*N + c] && row_open_i[i] && col_open_i[c]) begin
                grant_o[i*N + c] = 1'b1;
                row_open_o[i]    = 1'b0;
                col_open_o[c]    = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wfa_array.sv
module wfa_array #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [IW-1:0]  lead,
    input  logic [N*N-1:0] req,
    output logic [N*N-1:0] match
);

    logic [N-1:0]   row_open [0:N];
    logic [N-1:0]   col_open [0:N];
    logic [N*N-1:0] part     [0:N-1];

    assign row_open[0] = '1;
    assign col_open[0] = '1;

    for (genvar k = 0; k < N; k++) begin : g_wave
        wfa_wave #(
            .N  (N),
            .K  (k),
            .IW (IW)
        ) u_wave (
            .lead       (lead),
            .req        (req),
            .row_open_i (row_open[k]),
            .col_open_i (col_open[k]),
            .grant_o    (part[k]),
            .row_open_o (row_open[k+1]),
            .col_open_o (col_open[k+1])
        );
    end

    always_comb begin
        match = '0;
        for (int k = 0; k < N; k++) begin
            match = match | part[k];
        end
    end

endmodule

// File: rtl/wfa_arbiter.sv
module wfa_arbiter #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] req,
    output logic [N*N-1:0] grant
);

    localparam int IW = wfa_pkg::idx_width(N);

    logic [IW-1:0]  lead_q;
    logic [N*N-1:0] match_d;

    wfa_rotor #(
        .N  (N),
        .IW (IW)
    ) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .lead  (lead_q)
    );

    wfa_array #(
        .N  (N),
        .IW (IW)
    ) u_array (
        .lead  (lead_q),
        .req   (req),
        .match (match_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= '0;
        end else begin
            grant <= match_d;
        end
    end

endmodule

// File: rtl/wfa_arbiter_chk.sv
module wfa_arbiter_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N*N-1:0] req,
    input logic [N*N-1:0] grant,
    input logic [IW-1:0]  lead
);

    logic          past_ok;
    logic [IW-1:0] lead_prev;
    logic [IW-1:0] lead_exp;
    logic [N-1:0]  row_any;
    logic [N-1:0]  col_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            lead_prev <= '0;
        end else begin
            past_ok   <= 1'b1;
            lead_prev <= lead;
        end
    end

    assign lead_exp = (lead_prev == IW'(N - 1)) ? '0 : lead_prev + 1'b1;

    always_comb begin
        row_any = '0;
        col_any = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                row_any[i] = row_any[i] | grant[i*N + j];
                col_any[j] = col_any[j] | grant[i*N + j];
            end
        end
    end

    assert_grant_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((grant & ~$past(req)) == '0))
        else $error("grant without request");

    assert_no_req_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req) == '0) |-> (grant == '0))
        else $error("grant on empty request");

    assert_lead_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (lead == lead_exp))
        else $error("leading diagonal did not step by one");

    for (genvar i = 0; i < N; i++) begin : g_line
        assert_row_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[i*N +: N]))
            else $error("row with several grants");

        logic [N-1:0] col_bits;
        for (genvar r = 0; r < N; r++) begin : g_colbit
            assign col_bits[r] = grant[r*N + i];
        end

        assert_col_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_bits))
            else $error("column with several grants");

        for (genvar j = 0; j < N; j++) begin : g_cell
            assert_maximal_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(req[i*N + j])) |-> (row_any[i] || col_any[j]))
                else $error("request left idle between free row and column");
        end
    end

endmodule

bind wfa_arbiter wfa_arbiter_chk #(
    .N  (N),
    .IW (IW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .lead  (lead_q)
);

// File: tb/test_wfa_arbiter.sv
module test_wfa_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int NV = 8;

    // {req, expected grant}; entry e is sampled with leading diagonal e mod 4 (R7, R8).
    localparam logic [31:0] VEC [NV] = '{
        {16'hFFFF, 16'h2481},   // lead 0, all requests (R6)
        {16'hFFFF, 16'h4812},   // lead 1, all requests (R6)
        {16'h0011, 16'h0001},   // lead 2, two rows on column 0 (R6)
        {16'h0000, 16'h0000},   // lead 3, empty (R10)
        {16'h0011, 16'h0001},   // lead 0, row 0 wins (R6)
        {16'h0011, 16'h0010},   // lead 1, row 1 wins (R6)
        {16'h0213, 16'h0201},   // lead 2, mixed, maximal (R5, R6)
        {16'h8421, 16'h8421}    // lead 3, permutation (R9)
    };

    logic           clk;
    logic           rst_n;
    logic [N*N-1:0] req;
    logic [N*N-1:0] grant;

    int checks = 0;
    int fails  = 0;

    wfa_arbiter #(.N(N)) i_wfa_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit rows_ok(input logic [15:0] g);
        for (int i = 0; i < N; i++) if ($countones(g[i*N +: N]) > 1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit cols_ok(input logic [15:0] g);
        for (int j = 0; j < N; j++) begin
            int c = 0;
            for (int i = 0; i < N; i++) c += int'(g[i*N + j]);
            if (c > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit maximal(input logic [15:0] r, input logic [15:0] g);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                bit ra = |g[i*N +: N];
                bit ca = 1'b0;
                for (int k = 0; k < N; k++) ca |= g[k*N + j];
                if (r[i*N + j] && !ra && !ca) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int row0_wins;
        int row1_wins;
        rst_n = 1'b0;
        req   = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(grant, 16'h0000, "R1 reset clears grant");

        rst_n = 1'b1;
        for (int e = 0; e < NV; e++) begin
            req = VEC[e][31:16];
            @(negedge clk);
            chk(grant, VEC[e][15:0], $sformatf("R6 table entry %0d", e));
        end

        // Contended column 0: over 4 edges (lead 0..3) row 0 wins 3, row 1 wins 1 (R7).
        row0_wins = 0;
        row1_wins = 0;
        req = 16'h0011;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            row0_wins += int'(grant[0]);
            row1_wins += int'(grant[4]);
        end
        chk(16'(row0_wins), 16'd3, "R7 rotation share row 0");
        chk(16'(row1_wins), 16'd1, "R7 rotation share row 1");

        // Latency: a change of req is not visible before the next edge (R1).
        @(negedge clk);
        req = 16'h8421;
        #1;
        chk(grant, 16'h0001, "R1 grant holds until edge");
        @(negedge clk);
        chk(grant, 16'h8421, "R9 permutation after edge");

        // Random sweep on the match properties.
        for (int c = 0; c < 400; c++) begin
            logic [15:0] r;
            r = (c % 2 == 0) ? 16'($urandom) : 16'($urandom & $urandom);
            req = r;
            @(negedge clk);
            chk(16'(grant & ~r), 16'h0000, "R2 grant within request");
            chk(16'(rows_ok(grant)), 16'd1, "R3 one grant per row");
            chk(16'(cols_ok(grant)), 16'd1, "R4 one grant per column");
            chk(16'(maximal(r, grant)), 16'd1, "R5 maximal match");
        end

        // Reset in mid-run: grant clears at once, lead restarts at 0 (R1, R7).
        req   = 16'hFFFF;
        rst_n = 1'b0;
        #1;
        chk(grant, 16'h0000, "R1 asynchronous clear");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant, 16'h2481, "R7 restart at diagonal 0");
        @(negedge clk);
        chk(grant, 16'h4812, "R7 step to diagonal 1");
        req = 16'h0000;
        @(negedge clk);
        chk(grant, 16'h0000, "R10 empty request");

        finish_run();
    end

endmodule